// File: doc/BRIEF.md
# Configuration Mode Gate Controller

This block sits on a byte-wide register bus and keeps a configuration mode locked until software writes a magic value. It has three registers, picked by a 2-bit select: a command register, a leave register and a return register. The command register takes command bytes. Some of them are honoured only in certain modes. The leave and return registers take any written value as a request to lock configuration mode again. Reading the return register ends menu mode and turns the NMI back on.

Three pieces of state are kept: configuration mode, menu mode and NMI enable. Surrounding logic is driven by these flags, by a one-cycle soft-reset pulse and by a one-cycle core-start pulse that carries a 4-bit slot number. While either mode is active, a read of the command register returns a platform identification byte. A 2-bit strap input selects which byte.

Top module: `cfgmode_gate`

## Requirements
- R1: After reset, configuration mode and menu mode are off, NMI is enabled, and both pulse outputs are low.
- R2: Writing 0x2A to the command register (select 0) sets configuration mode on the next cycle. Writing 0xFF there clears it. Both bytes act in any mode.
- R3: Any write to the leave register (select 1) or the return register (select 2) clears configuration mode on the next cycle. Writes to select 3 have no effect.
- R4: A read of the return register (select 2) clears menu mode and sets NMI enable on the next cycle.
- R5: Command 0x20 sets menu mode. Command 0x21 sets menu mode and clears NMI enable. Both act only while configuration mode is on.
- R6: Command 0x22 sets NMI enable and command 0x23 clears it. Both act only while configuration or menu mode is on.
- R7: Commands 0xA5 and 0xA6, written while configuration or menu mode is on, raise the soft-reset pulse on the next cycle. Command 0xA6 also clears configuration mode.
- R8: A command byte whose upper nibble is 0x1, written while configuration or menu mode is on, raises the core-start pulse on the next cycle. In that same cycle the slot output carries the byte's lower nibble.
- R9: While configuration or menu mode is on, read data for the command register is a combinational platform ID set by the strap: 0→0x01, 1→0xA1, 2→0xC1, 3→0xD1.
- R10: With both modes off, read data for the command register is 0xFF. Read data for the other three registers is always 0x00.
- R11: A command written outside the mode it needs changes nothing. Any command-register byte not named in R2 and R5–R8 changes nothing.
- R12: Each command that is accepted produces a pulse of exactly one cycle. The pulse falls on the next cycle unless another accepted command follows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 command, 1 leave, 2 return, 3 spare |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from select and state |
| plat_strap | input | 2 | Platform identity strap |
| cfg_active | output | 1 | Configuration mode flag |
| menu_active | output | 1 | Menu mode flag |
| nmi_en | output | 1 | NMI enable flag |
| soft_rst_pulse | output | 1 | One-cycle soft-reset request |
| core_start_pulse | output | 1 | One-cycle core-start request |
| core_slot | output | 4 | Slot number that goes with the core-start request |

## Verification
A wrong mode flag shows up at the mode outputs one cycle after the access that caused it. It also changes the command-register read data at once, because that read returns either a platform ID or 0xFF. A mode gate that has gone wrong is harder to see. It is exposed one cycle later, when a gated command either produces a pulse it should not or fails to produce one. The bench therefore compares the flags, the pulses and the read data against an independent model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/cfgmode_pkg.sv
package cfgmode_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CMD    = 2'd0,
    SEL_LEAVE  = 2'd1,
    SEL_RETURN = 2'd2,
    SEL_SPARE  = 2'd3
  } sel_e;

  localparam logic [BYTE_W-1:0] CMD_UNLOCK     = 8'h2A;
  localparam logic [BYTE_W-1:0] CMD_LOCK       = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_MENU       = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_MENU_QUIET = 8'h21;
  localparam logic [BYTE_W-1:0] CMD_NMI_ON     = 8'h22;
  localparam logic [BYTE_W-1:0] CMD_NMI_OFF    = 8'h23;
  localparam logic [BYTE_W-1:0] CMD_RESET      = 8'hA5;
  localparam logic [BYTE_W-1:0] CMD_RESET_LOCK = 8'hA6;
  localparam logic [3:0]        CMD_START_HI   = 4'h1;
  localparam logic [BYTE_W-1:0] RD_LOCKED      = 8'hFF;
  localparam logic [BYTE_W-1:0] RD_EMPTY       = 8'h00;

  // Actions one bus access can request
  typedef struct packed {
    logic set_cfg;
    logic clr_cfg;
    logic set_menu;
    logic clr_menu;
    logic set_nmi;
    logic clr_nmi;
    logic soft_rst;
    logic start;
  } act_t;

  function automatic logic [BYTE_W-1:0] platform_id(input logic [1:0] strap);
    case (strap)
      2'd0:    return 8'h01;
      2'd1:    return 8'hA1;
      2'd2:    return 8'hC1;
      default: return 8'hD1;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] cmd_read(input logic unlocked,
                                                 input logic [1:0] strap);
    return unlocked ? platform_id(strap) : RD_LOCKED;
  endfunction
endpackage

// File: rtl/cfgmode_decode.sv
module cfgmode_decode
  import cfgmode_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  sel_e              sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cfg_q,
  input  logic              menu_q,
  output act_t              act,
  output logic [SLOT_W-1:0] slot
);
  localparam int HI_W = BYTE_W - SLOT_W;

  logic unlocked;
  assign unlocked = cfg_q | menu_q;
  assign slot     = wdata[SLOT_W-1:0];

  always_comb begin
    act = '0;
    if (wr_en) begin
      case (sel)
        SEL_CMD: begin
          case (wdata)
            CMD_UNLOCK:     act.set_cfg = 1'b1;
            CMD_LOCK:       act.clr_cfg = 1'b1;
            CMD_MENU:       act.set_menu = cfg_q;
            CMD_MENU_QUIET: begin
              act.set_menu = cfg_q;
              act.clr_nmi  = cfg_q;
            end
            CMD_NMI_ON:     act.set_nmi  = unlocked;
            CMD_NMI_OFF:    act.clr_nmi  = unlocked;
            CMD_RESET:      act.soft_rst = unlocked;
            CMD_RESET_LOCK: begin
              act.soft_rst = unlocked;
              act.clr_cfg  = unlocked;
            end
            default: act.start = unlocked &&
                                 (wdata[BYTE_W-1:SLOT_W] == HI_W'(CMD_START_HI));
          endcase
        end
        SEL_LEAVE, SEL_RETURN: act.clr_cfg = 1'b1;
        default: ;
      endcase
    end
    if (rd_en && sel == SEL_RETURN) begin
      act.clr_menu = 1'b1;
      act.set_nmi  = 1'b1;
    end
  end
endmodule

// File: rtl/cfgmode_state.sv
module cfgmode_state
  import cfgmode_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_t              act,
  input  logic [SLOT_W-1:0] slot_in,
  output logic              cfg_q,
  output logic              menu_q,
  output logic              nmi_q,
  output logic              soft_rst_q,
  output logic              start_q,
  output logic [SLOT_W-1:0] slot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= 1'b0;
      menu_q     <= 1'b0;
      nmi_q      <= 1'b1;
      soft_rst_q <= 1'b0;
      start_q    <= 1'b0;
      slot_q     <= '0;
    end else begin
      if (act.set_cfg)       cfg_q <= 1'b1;
      else if (act.clr_cfg)  cfg_q <= 1'b0;
      if (act.set_menu)      menu_q <= 1'b1;
      else if (act.clr_menu) menu_q <= 1'b0;
      if (act.set_nmi)       nmi_q <= 1'b1;
      else if (act.clr_nmi)  nmi_q <= 1'b0;
      soft_rst_q <= act.soft_rst;
      start_q    <= act.start;
      if (act.start) slot_q <= slot_in;
    end
  end
endmodule

// File: rtl/cfgmode_readmux.sv
module cfgmode_readmux
  import cfgmode_pkg::*;
(
  input  sel_e              sel,
  input  logic              cfg_q,
  input  logic              menu_q,
  input  logic [1:0]        strap,
  output logic [BYTE_W-1:0] rdata
);
  always_comb begin
    if (sel == SEL_CMD) rdata = cmd_read(cfg_q | menu_q, strap);
    else                rdata = RD_EMPTY;
  end
endmodule

// File: rtl/cfgmode_gate.sv
module cfgmode_gate
  import cfgmode_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        plat_strap,
  output logic              cfg_active,
  output logic              menu_active,
  output logic              nmi_en,
  output logic              soft_rst_pulse,
  output logic              core_start_pulse,
  output logic [SLOT_W-1:0] core_slot
);
  sel_e              sel;
  act_t              act;
  logic [SLOT_W-1:0] dec_slot;
  // Decoder events brought out as named wires for the checker
  logic              ev_soft_rst;
  logic              ev_start;

  assign sel         = sel_e'(bus_sel);
  assign ev_soft_rst = act.soft_rst;
  assign ev_start    = act.start;

  cfgmode_decode #(.SLOT_W(SLOT_W)) u_decode (
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .sel    (sel),
    .wdata  (bus_wdata),
    .cfg_q  (cfg_active),
    .menu_q (menu_active),
    .act    (act),
    .slot   (dec_slot)
  );

  cfgmode_state #(.SLOT_W(SLOT_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .slot_in    (dec_slot),
    .cfg_q      (cfg_active),
    .menu_q     (menu_active),
    .nmi_q      (nmi_en),
    .soft_rst_q (soft_rst_pulse),
    .start_q    (core_start_pulse),
    .slot_q     (core_slot)
  );

  cfgmode_readmux u_readmux (
    .sel    (sel),
    .cfg_q  (cfg_active),
    .menu_q (menu_active),
    .strap  (plat_strap),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/cfgmode_gate_chk.sv
module cfgmode_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_sel,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [1:0] plat_strap,
  input logic       cfg_active,
  input logic       menu_active,
  input logic       nmi_en,
  input logic       soft_rst_pulse,
  input logic       core_start_pulse,
  input logic [3:0] core_slot,
  input logic       ev_soft_rst,
  input logic       ev_start
);
  logic cmd_wr;
  logic [7:0] exp_id;
  assign cmd_wr = bus_wr && bus_sel == 2'd0;
  assign exp_id = (plat_strap == 2'd0) ? 8'h01 : (plat_strap == 2'd1) ? 8'hA1 :
                  (plat_strap == 2'd2) ? 8'hC1 : 8'hD1;

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cfg_active && !menu_active && nmi_en && !soft_rst_pulse);
  assert_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && bus_wdata == 8'h2A |=> cfg_active);
  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && bus_wdata == 8'hFF |=> !cfg_active);
  assert_exit_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_sel == 2'd1 || bus_sel == 2'd2) |=> !cfg_active);
  assert_return_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_sel == 2'd2 |=> !menu_active && nmi_en);
  assert_menu_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && (bus_wdata == 8'h20 || bus_wdata == 8'h21) && !cfg_active
    |=> menu_active == $past(menu_active));
  assert_nmi_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && bus_wdata == 8'h23 && (cfg_active || menu_active) |=> !nmi_en);
  assert_soft_rst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_soft_rst |=> soft_rst_pulse);
  assert_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> core_start_pulse && core_slot == $past(bus_wdata[3:0]));
  assert_platform_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 2'd0 && (cfg_active || menu_active) |-> bus_rdata == exp_id);
  assert_locked_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 2'd0 && !cfg_active && !menu_active |-> bus_rdata == 8'hFF);
  assert_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_active && !menu_active |=> !soft_rst_pulse && !core_start_pulse);
  assert_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_soft_rst && !ev_start |=> !soft_rst_pulse && !core_start_pulse);
endmodule

bind cfgmode_gate cfgmode_gate_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .bus_sel          (bus_sel),
  .bus_wr           (bus_wr),
  .bus_rd           (bus_rd),
  .bus_wdata        (bus_wdata),
  .bus_rdata        (bus_rdata),
  .plat_strap       (plat_strap),
  .cfg_active       (cfg_active),
  .menu_active      (menu_active),
  .nmi_en           (nmi_en),
  .soft_rst_pulse   (soft_rst_pulse),
  .core_start_pulse (core_start_pulse),
  .core_slot        (core_slot),
  .ev_soft_rst      (ev_soft_rst),
  .ev_start         (ev_start)
);

// File: tb/test_cfgmode_gate.sv
`timescale 1ns/1ps
module test_cfgmode_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [1:0] plat_strap = 2'd0;
  logic       cfg_active, menu_active, nmi_en, soft_rst_pulse, core_start_pulse;
  logic [3:0] core_slot;

  int vectors = 0;
  int misses  = 0;
  bit m_cfg = 1'b0, m_menu = 1'b0, m_nmi = 1'b1, m_rst = 1'b0, m_go = 1'b0;
  logic [3:0] m_slot = 4'd0;

  always #5 clk = ~clk;

  cfgmode_gate i_cfgmode_gate (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .plat_strap(plat_strap),
    .cfg_active(cfg_active), .menu_active(menu_active), .nmi_en(nmi_en),
    .soft_rst_pulse(soft_rst_pulse), .core_start_pulse(core_start_pulse),
    .core_slot(core_slot)
  );

  function automatic logic [7:0] id_of(input logic [1:0] s);
    logic [7:0] tbl [4] = '{8'h01, 8'hA1, 8'hC1, 8'hD1};
    return tbl[s];
  endfunction

  function automatic logic [7:0] exp_rd(input logic [1:0] s, input bit c,
                                        input bit m, input logic [1:0] st);
    if (s != 2'd0) return 8'h00;
    return (c || m) ? id_of(st) : 8'hFF;
  endfunction

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp,
                     input string tag, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string tag);
    cmp({7'd0, cfg_active}, {7'd0, m_cfg}, tag, "cfg");
    cmp({7'd0, menu_active}, {7'd0, m_menu}, tag, "menu");
    cmp({7'd0, nmi_en}, {7'd0, m_nmi}, tag, "nmi");
    cmp({7'd0, soft_rst_pulse}, {7'd0, m_rst}, tag, "soft_rst");
    cmp({7'd0, core_start_pulse}, {7'd0, m_go}, tag, "start");
    if (m_go) cmp({4'd0, core_slot}, {4'd0, m_slot}, tag, "slot");
  endtask

  // One bus cycle: check results of the previous cycle, drive, model the next state
  task automatic op(input bit wr, input bit rd, input logic [1:0] sel,
                    input logic [7:0] d, input string tag);
    bit oc, om, any;
    @(negedge clk);
    check_outs(tag);
    bus_wr = wr; bus_rd = rd; bus_sel = sel; bus_wdata = d;
    #1;
    if (rd) cmp(bus_rdata, exp_rd(sel, m_cfg, m_menu, plat_strap), tag, "rdata");
    oc = m_cfg; om = m_menu; any = oc || om;
    m_rst = 1'b0; m_go = 1'b0;
    if (wr && sel == 2'd0) begin
      if (d == 8'h2A) m_cfg = 1'b1;
      else if (d == 8'hFF) m_cfg = 1'b0;
      else if (d == 8'h20 && oc) m_menu = 1'b1;
      else if (d == 8'h21 && oc) begin m_menu = 1'b1; m_nmi = 1'b0; end
      else if (d == 8'h22 && any) m_nmi = 1'b1;
      else if (d == 8'h23 && any) m_nmi = 1'b0;
      else if (d == 8'hA5 && any) m_rst = 1'b1;
      else if (d == 8'hA6 && any) begin m_rst = 1'b1; m_cfg = 1'b0; end
      else if (d[7:4] == 4'h1 && any) begin m_go = 1'b1; m_slot = d[3:0]; end
    end
    if (wr && (sel == 2'd1 || sel == 2'd2)) m_cfg = 1'b0;
    if (rd && sel == 2'd2) begin m_menu = 1'b0; m_nmi = 1'b1; end
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 2'd3, 8'h00, tag);
  endtask

  initial begin
    #2_000_000;
    misses++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle("R1");
    // R10: locked reads
    op(0, 1, 2'd0, 8'h00, "R10");
    op(0, 1, 2'd1, 8'h00, "R10");
    op(0, 1, 2'd3, 8'h00, "R10");
    // R11: gated commands before unlocking
    op(1, 0, 2'd0, 8'hA5, "R11");
    op(1, 0, 2'd0, 8'h13, "R11");
    op(1, 0, 2'd0, 8'h21, "R11");
    op(1, 0, 2'd0, 8'h23, "R11");
    op(1, 0, 2'd3, 8'h2A, "R11");
    // R2: unlock; R9: ID for every strap
    op(1, 0, 2'd0, 8'h2A, "R2");
    for (int s = 0; s < 4; s++) begin
      plat_strap = s[1:0];
      op(0, 1, 2'd0, 8'h00, "R9");
    end
    op(0, 1, 2'd2, 8'h00, "R10");
    // R11: unlisted byte
    op(1, 0, 2'd0, 8'h55, "R11");
    // R5, R6, R7, R8, R12
    op(1, 0, 2'd0, 8'h21, "R5");
    op(1, 0, 2'd0, 8'h22, "R6");
    op(1, 0, 2'd0, 8'hA5, "R7");
    idle("R12");
    op(1, 0, 2'd0, 8'h1C, "R8");
    op(1, 0, 2'd0, 8'h17, "R8");
    idle("R12");
    // R3: leave write, then commands accepted in menu mode only
    op(1, 0, 2'd1, 8'h00, "R3");
    op(1, 0, 2'd0, 8'h20, "R5");
    op(1, 0, 2'd0, 8'h23, "R6");
    op(1, 0, 2'd0, 8'hA6, "R7");
    op(0, 1, 2'd0, 8'h00, "R9");
    // R4: return read leaves menu, restores NMI
    op(0, 1, 2'd2, 8'h00, "R4");
    op(0, 1, 2'd0, 8'h00, "R10");
    op(1, 0, 2'd0, 8'h2A, "R2");
    op(1, 0, 2'd2, 8'h5A, "R3");
    op(1, 0, 2'd0, 8'h2A, "R2");
    op(1, 0, 2'd0, 8'hFF, "R2");
    idle("R2");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] d;
      logic [1:0] s;
      case ($urandom % 10)
        0: d = 8'h2A; 1: d = 8'hFF; 2: d = 8'h20; 3: d = 8'h21; 4: d = 8'h22;
        5: d = 8'h23; 6: d = 8'hA5; 7: d = 8'hA6; 8: d = {4'h1, 4'($urandom)};
        default: d = 8'($urandom);
      endcase
      s = ($urandom % 4 != 0) ? 2'd0 : 2'($urandom);
      plat_strap = 2'($urandom);
      op(($urandom % 3) != 0, ($urandom % 3) == 0, s, d, "R11");
    end
    idle("R12");
    @(negedge clk);
    check_outs("R12");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule